// File: doc/BRIEF.md
# Pipelined Synchronous DRAM Front End

This block models the command side of a clocked dynamic memory in synthesizable form, backed by a small on-chip array. Every input is taken on the rising clock edge: the command, the bank and address, the write data and the data mask. A row is opened with an activate command. After the row-to-column delay, read and write commands address columns inside the open row. Read data comes back a fixed, programmable number of cycles after the read command. That latency is set by a configuration command, so the requester always knows in which cycle its data will arrive.

An input register holds the newest command while earlier reads travel down the return pipeline. A read can therefore be issued on every cycle, and the data returns in order, one beat per cycle. The data-mask pin drops the write carried in the same cycle. When high at the edge where read data would appear, it also blanks that single output beat. Clock enable freezes every register of the block, so a stalled access resumes exactly where it stopped.

Top module: `sdram_front`

## Requirements
- R1: On synchronous reset, `rvalid` and `cmd_err` are low, `rdata` is zero, every bank is closed and the read latency is 3.
- R2: A configure command (`cmd`=5) loads the read latency from `addr[3:0]` when that value lies in 2..MAX_LAT (default 6). Any other value leaves the latency unchanged.
- R3: A read (`cmd`=2) captured at edge k returns its word with `rvalid` high in exactly the cycle after edge k+L, where L is the current latency. `rvalid` stays low in the cycle before.
- R4: An activate (`cmd`=1) opens row `addr[2:0]` of bank `bank`. A read or write (`cmd`=3) to that bank is accepted only if captured at least RCD (default 3) edges after the activate. An earlier one raises `cmd_err` for one cycle after the following edge and is ignored.
- R5: A read or write to a closed bank raises `cmd_err` in the cycle after the edge that follows its capture. It writes nothing and returns no data.
- R6: Reads issued on consecutive cycles return their words in order on consecutive cycles.
- R7: A write captured with `dm` high leaves the array unchanged.
- R8: When `dm` is high at the edge where a read word would appear, `rvalid` is low and `rdata` is zero for that one cycle. A read due on the next edge is not affected.
- R9: While `cke` is low, no input is captured and no state or output changes. After `cke` returns high, pending reads complete with their latency counted in enabled edges only.
- R10: A precharge command (`cmd`=4) closes the addressed bank. Later column commands to it follow R5.
- R11: Data written at column `addr[3:0]` of an open row is returned by a later read of the same bank, row and column. Open rows in different banks are kept independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cmd | input | 3 | 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 configure |
| bank | input | $clog2(NB) | Bank select |
| addr | input | ADDR_W | Row on activate, column on read/write, latency on configure |
| wdata | input | DW | Write data, taken with the write command |
| dm | input | 1 | Data mask: drops the write of this cycle and blanks the read beat due now |
| rdata | output | DW | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| cmd_err | output | 1 | Column command refused (bank closed or too early) |

## Verification
The mask pin serves two functions that can fall on the same edge. One is dropping the write carried in the input register. The other is blanking a read beat that an earlier read scheduled for that very edge. The bench issues a read, waits until one edge before its data is due, and then presents a write with the mask high on that edge. It checks that the output beat is blanked, and a later read of the written column shows the old contents. The same pattern with the mask low must deliver both the read beat and the new contents.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_CFG = 3'd5
  } cmd_e;

  localparam int LAT_RESET = 3;
  localparam int LAT_MIN   = 2;
endpackage

// File: rtl/sdf_bank_ctl.sv
module sdf_bank_ctl #(
  parameter int ROW_W = 3,
  parameter int RCD   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rdy_o
);
  localparam int CW = $clog2(RCD);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      row_o  <= '0;
      wait_q <= '0;
    end else if (cke) begin
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        wait_q <= CW'(RCD - 1);
      end else begin
        if (pre_i) open_o <= 1'b0;
        if (wait_q != '0) wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign rdy_o = open_o && (wait_q == '0);

  // R4: a freshly activated row is open but not yet usable
  p_act_blocks_col_r4: assert property (@(posedge clk) disable iff (rst)
    (cke && act_i) |=> (open_o && !rdy_o));

  // R10: precharge closes the bank
  p_pre_closes_r10: assert property (@(posedge clk) disable iff (rst)
    (cke && pre_i && !act_i) |=> !open_o);

  // R9: frozen while clock enable is low
  p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(open_o) && $stable(rdy_o) && $stable(row_o)));
endmodule

// File: rtl/sdf_array.sv
module sdf_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cke,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cke) begin
      if (we) mem[addr] <= wd;
      rq <= mem[addr];
    end
  end
endmodule

// File: rtl/sdf_rd_pipe.sv
module sdf_rd_pipe #(
  parameter int DW      = 8,
  parameter int MAX_LAT = 6,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic [LAT_W-1:0] lat,
  input  logic             v_in,
  input  logic [DW-1:0]    d0_in,
  input  logic             dm,
  output logic             rvalid,
  output logic [DW-1:0]    rdata
);
  localparam int NST = MAX_LAT - 2;

  logic          v0_q;
  logic          sh_v [1:NST];
  logic [DW-1:0] sh_d [1:NST];
  logic          sel_v;
  logic [DW-1:0] sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q <= 1'b0;
      for (int i = 1; i <= NST; i++) sh_v[i] <= 1'b0;
    end else if (cke) begin
      v0_q    <= v_in;
      sh_v[1] <= v0_q;
      for (int i = 2; i <= NST; i++) sh_v[i] <= sh_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (cke) begin
      sh_d[1] <= d0_in;
      for (int i = 2; i <= NST; i++) sh_d[i] <= sh_d[i-1];
    end
  end

  always_comb begin
    sel_v = v0_q;
    sel_d = d0_in;
    for (int i = 1; i <= NST; i++) begin
      if (lat == LAT_W'(i + 2)) begin
        sel_v = sh_v[i];
        sel_d = sh_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (cke) begin
      rvalid <= sel_v && !dm;
      rdata  <= (sel_v && !dm) ? sel_d : '0;
    end
  end

  // R8: a masked beat is blank
  p_mask_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (cke && dm) |=> (!rvalid && rdata == '0));

  // R9: outputs hold while clock enable is low
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(rvalid) && $stable(rdata)));
endmodule

// File: rtl/sdram_front.sv
module sdram_front
  import sdf_pkg::*;
#(
  parameter int NB      = 2,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int DW      = 8,
  parameter int MAX_LAT = 6,
  parameter int RCD     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic [2:0]            cmd,
  input  logic [$clog2(NB)-1:0] bank,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DW-1:0]         wdata,
  input  logic                  dm,
  output logic [DW-1:0]         rdata,
  output logic                  rvalid,
  output logic                  cmd_err
);
  localparam int BANK_W = $clog2(NB);
  localparam int LAT_W  = $clog2(MAX_LAT + 1);
  localparam int MEM_AW = BANK_W + ROW_W + COL_W;

  // input register: holds the newest request while older reads drain
  logic [2:0]        lat_cmd;
  logic [BANK_W-1:0] lat_bank;
  logic [ADDR_W-1:0] lat_addr;
  logic [DW-1:0]     lat_wd;
  logic              lat_dm;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cmd  <= CMD_NOP;
      lat_bank <= '0;
      lat_addr <= '0;
      lat_wd   <= '0;
      lat_dm   <= 1'b0;
    end else if (cke) begin
      lat_cmd  <= cmd;
      lat_bank <= bank;
      lat_addr <= addr;
      lat_wd   <= wdata;
      lat_dm   <= dm;
    end
  end

  logic is_act, is_pre, is_rd, is_wr, is_cfg, is_col;
  assign is_act = (lat_cmd == CMD_ACT);
  assign is_pre = (lat_cmd == CMD_PRE);
  assign is_rd  = (lat_cmd == CMD_RD);
  assign is_wr  = (lat_cmd == CMD_WR);
  assign is_cfg = (lat_cmd == CMD_CFG);
  assign is_col = is_rd || is_wr;

  logic             bank_open [NB];
  logic             bank_rdy  [NB];
  logic [ROW_W-1:0] bank_row  [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdf_bank_ctl #(.ROW_W(ROW_W), .RCD(RCD)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .cke    (cke),
      .act_i  (is_act && lat_bank == BANK_W'(g)),
      .pre_i  (is_pre && lat_bank == BANK_W'(g)),
      .row_i  (lat_addr[ROW_W-1:0]),
      .open_o (bank_open[g]),
      .row_o  (bank_row[g]),
      .rdy_o  (bank_rdy[g])
    );
  end

  logic col_ok, do_rd, do_wr;
  assign col_ok = bank_rdy[lat_bank];
  assign do_rd  = is_rd && col_ok;
  assign do_wr  = is_wr && col_ok && !lat_dm;

  // mode register
  logic [LAT_W-1:0] lat_q;
  logic             cfg_legal;
  assign cfg_legal = (lat_addr[3:0] >= 4'(LAT_MIN)) && (lat_addr[3:0] <= 4'(MAX_LAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= LAT_W'(LAT_RESET);
      cmd_err <= 1'b0;
    end else if (cke) begin
      if (is_cfg && cfg_legal) lat_q <= LAT_W'(lat_addr[3:0]);
      cmd_err <= is_col && !col_ok;
    end
  end

  logic [MEM_AW-1:0] mem_addr;
  logic [DW-1:0]     mem_q;
  assign mem_addr = {lat_bank, bank_row[lat_bank], lat_addr[COL_W-1:0]};

  sdf_array #(.AW(MEM_AW), .DW(DW)) u_array (
    .clk  (clk),
    .cke  (cke),
    .we   (do_wr),
    .addr (mem_addr),
    .wd   (lat_wd),
    .rq   (mem_q)
  );

  sdf_rd_pipe #(.DW(DW), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .cke    (cke),
    .lat    (lat_q),
    .v_in   (do_rd),
    .d0_in  (mem_q),
    .dm     (dm),
    .rvalid (rvalid),
    .rdata  (rdata)
  );

  // R2: latency always within the supported range
  p_lat_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (lat_q >= LAT_W'(LAT_MIN)) && (lat_q <= LAT_W'(MAX_LAT)));

  // R5: column command to a closed bank is refused
  p_closed_err_r5: assert property (@(posedge clk) disable iff (rst)
    (cke && is_col && !bank_open[lat_bank]) |=> cmd_err);

  // R9: error flag holds while frozen
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(cmd_err));
endmodule

// File: tb/sdram_front_test.sv
`timescale 1ns/1ps
module sdram_front_test;
  import sdf_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic       cke;
  logic [2:0] cmd;
  logic [0:0] bank;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       dm;
  logic [7:0] rdata;
  logic       rvalid;
  logic       cmd_err;

  always #10 clk = ~clk;

  sdram_front uut (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank(bank), .addr(addr),
    .wdata(wdata), .dm(dm), .rdata(rdata), .rvalid(rvalid), .cmd_err(cmd_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic [2:0] c, input logic b, input logic [3:0] a,
                     input logic [7:0] wd, input logic m, input logic ce);
    cmd = c; bank = b; addr = a; wdata = wd; dm = m; cke = ce;
    @(negedge clk);
  endtask

  task automatic nop();
    drv(CMD_NOP, 1'b0, 4'd0, 8'd0, 1'b0, 1'b1);
  endtask

  task automatic rd_chk(input logic b, input logic [3:0] c, input int lat,
                        input logic [7:0] exp, input string req);
    drv(CMD_RD, b, c, 8'd0, 1'b0, 1'b1);
    repeat (lat - 1) nop();
    chk(req, "rvalid one cycle early", rvalid, 1'b0);
    nop();
    chk(req, "rvalid at latency", rvalid, 1'b1);
    chk(req, "rdata at latency", rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1", "rvalid after reset", rvalid, 1'b0);
    chk("R1", "rdata after reset", rdata, 8'h00);
    chk("R1", "cmd_err after reset", cmd_err, 1'b0);
  endtask

  task automatic t_basic();
    drv(CMD_ACT, 1'b0, 4'd2, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    drv(CMD_WR, 1'b0, 4'd5, 8'hA5, 1'b0, 1'b1);
    rd_chk(1'b0, 4'd5, 3, 8'hA5, "R1 default latency / R11");
    nop();
    chk("R3", "single beat", rvalid, 1'b0);
  endtask

  task automatic t_pipeline();
    for (int i = 0; i < 4; i++) drv(CMD_WR, 1'b0, 4'(i), 8'(8'h10 + i), 1'b0, 1'b1);
    drv(CMD_WR, 1'b0, 4'd7, 8'h11, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) drv(CMD_RD, 1'b0, 4'(i), 8'd0, 1'b0, 1'b1);
    chk("R6", "beat0 valid", rvalid, 1'b1);
    chk("R6", "beat0 data", rdata, 8'h10);
    for (int i = 1; i < 4; i++) begin
      nop();
      chk("R6", "beat valid", rvalid, 1'b1);
      chk("R6", "beat data", rdata, 8'(8'h10 + i));
    end
    nop();
    chk("R6", "stream ends", rvalid, 1'b0);
  endtask

  task automatic t_rcd();
    drv(CMD_ACT, 1'b1, 4'd5, 8'd0, 1'b0, 1'b1);
    drv(CMD_RD, 1'b1, 4'd1, 8'd0, 1'b0, 1'b1);
    nop();
    chk("R4", "early column flagged", cmd_err, 1'b1);
    nop(); nop();
    chk("R4", "early read gives no data", rvalid, 1'b0);
    drv(CMD_WR, 1'b1, 4'd1, 8'h77, 1'b0, 1'b1);
    nop();
    chk("R4", "timely column accepted", cmd_err, 1'b0);
    rd_chk(1'b1, 4'd1, 3, 8'h77, "R11 bank1");
    rd_chk(1'b0, 4'd5, 3, 8'hA5, "R11 bank0 kept");
  endtask

  task automatic t_closed();
    drv(CMD_PRE, 1'b1, 4'd0, 8'd0, 1'b0, 1'b1);
    nop();
    drv(CMD_WR, 1'b1, 4'd1, 8'h99, 1'b0, 1'b1);
    nop();
    chk("R5", "write to closed bank flagged", cmd_err, 1'b1);
    drv(CMD_RD, 1'b1, 4'd1, 8'd0, 1'b0, 1'b1);
    nop();
    chk("R10", "read after precharge flagged", cmd_err, 1'b1);
    nop(); nop();
    chk("R5", "closed read gives no data", rvalid, 1'b0);
    drv(CMD_ACT, 1'b1, 4'd5, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    rd_chk(1'b1, 4'd1, 3, 8'h77, "R5 write ignored");
  endtask

  task automatic t_cfg();
    drv(CMD_CFG, 1'b0, 4'd5, 8'd0, 1'b0, 1'b1); nop();
    rd_chk(1'b0, 4'd5, 5, 8'hA5, "R2 latency 5");
    drv(CMD_CFG, 1'b0, 4'd7, 8'd0, 1'b0, 1'b1); nop();
    rd_chk(1'b0, 4'd5, 5, 8'hA5, "R2 value 7 refused");
    drv(CMD_CFG, 1'b0, 4'd1, 8'd0, 1'b0, 1'b1); nop();
    rd_chk(1'b0, 4'd5, 5, 8'hA5, "R2 value 1 refused");
    drv(CMD_CFG, 1'b0, 4'd2, 8'd0, 1'b0, 1'b1); nop();
    rd_chk(1'b0, 4'd0, 2, 8'h10, "R2 latency 2");
    drv(CMD_CFG, 1'b0, 4'd6, 8'd0, 1'b0, 1'b1); nop();
    rd_chk(1'b0, 4'd1, 6, 8'h11, "R2 latency 6");
    drv(CMD_CFG, 1'b0, 4'd3, 8'd0, 1'b0, 1'b1); nop();
  endtask

  task automatic t_mask_wr();
    drv(CMD_WR, 1'b0, 4'd5, 8'h3C, 1'b1, 1'b1);
    rd_chk(1'b0, 4'd5, 3, 8'hA5, "R7 masked write dropped");
  endtask

  task automatic t_mask_rd();
    drv(CMD_RD, 1'b0, 4'd0, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    drv(CMD_NOP, 1'b0, 4'd0, 8'd0, 1'b1, 1'b1);
    chk("R8", "masked beat rvalid", rvalid, 1'b0);
    chk("R8", "masked beat rdata", rdata, 8'h00);
    drv(CMD_RD, 1'b0, 4'd0, 8'd0, 1'b0, 1'b1);
    drv(CMD_RD, 1'b0, 4'd1, 8'd0, 1'b0, 1'b1);
    nop();
    drv(CMD_NOP, 1'b0, 4'd0, 8'd0, 1'b1, 1'b1);
    chk("R8", "first of pair masked", rvalid, 1'b0);
    nop();
    chk("R8", "second of pair valid", rvalid, 1'b1);
    chk("R8", "second of pair data", rdata, 8'h11);
  endtask

  task automatic t_collide();
    drv(CMD_RD, 1'b0, 4'd2, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    drv(CMD_WR, 1'b0, 4'd7, 8'h5A, 1'b1, 1'b1);
    chk("R8", "beat blanked by write mask", rvalid, 1'b0);
    chk("R8", "blanked data zero", rdata, 8'h00);
    rd_chk(1'b0, 4'd7, 3, 8'h11, "R7 colliding masked write dropped");
    drv(CMD_RD, 1'b0, 4'd2, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    drv(CMD_WR, 1'b0, 4'd7, 8'h6B, 1'b0, 1'b1);
    chk("R3", "unmasked beat during write", rvalid, 1'b1);
    chk("R3", "unmasked data during write", rdata, 8'h12);
    rd_chk(1'b0, 4'd7, 3, 8'h6B, "R11 colliding write lands");
  endtask

  task automatic t_cke();
    drv(CMD_RD, 1'b0, 4'd3, 8'd0, 1'b0, 1'b1);
    nop(); nop();
    repeat (3) drv(CMD_NOP, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0);
    chk("R9", "no data while frozen", rvalid, 1'b0);
    nop();
    chk("R9", "resumed beat valid", rvalid, 1'b1);
    chk("R9", "resumed beat data", rdata, 8'h13);
    drv(CMD_NOP, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0);
    chk("R9", "beat held while frozen", rvalid, 1'b1);
    chk("R9", "data held while frozen", rdata, 8'h13);
    nop();
    chk("R9", "beat drops after resume", rvalid, 1'b0);
    drv(CMD_WR, 1'b0, 4'd2, 8'hEE, 1'b0, 1'b0);
    nop();
    rd_chk(1'b0, 4'd2, 3, 8'h12, "R9 frozen write not taken");
  endtask

  initial begin
    rst = 1'b1; cke = 1'b1; cmd = CMD_NOP; bank = 1'b0; addr = 4'd0;
    wdata = 8'd0; dm = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_pipeline();
    t_rcd();
    t_closed();
    t_cfg();
    t_mask_wr();
    t_mask_rd();
    t_collide();
    t_cke();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule